// File: doc/BRIEF.md
# Nibble Time-Slot Interchange Switch

This block is a time-slot interchange that switches 4-bit sub-channels at 32 kb/s. Each serial stream runs at 2.048 Mb/s and carries 64 nibbles per frame. The default build has eight input streams and four output streams, so 512 source nibbles compete for 256 output nibble slots. That layout is blocking. Traffic can be confined to any four of the inputs to get a one-to-one, non-blocking 256 x 256 arrangement. The block runs from a 4.096 MHz clock, which is two clocks per serial bit.

Incoming nibbles are converted from serial to parallel and stored in a data memory with two banks. One bank fills during the current frame while the other, holding the previous frame, is read out. A connection memory holds one entry for each output nibble slot. The entry names the source stream and the source nibble index. Every output nibble is therefore a copy of a chosen input nibble from the previous frame, with a fixed delay. A frame pulse aligns nibble 0 on both the input and the output side. Between pulses the timing runs free.

Top module: `nib_tdm_switch`

## Requirements
- R1: A frame is 512 clocks: 64 nibbles, 4 bits per nibble, 2 clocks per bit. `frame_sync` high in a clock marks that clock as the first clock of bit 0 of nibble 0. Without `frame_sync`, the position wraps to nibble 0 every 512 clocks.
- R2: Each input nibble is received most significant bit first. Each bit is sampled only on the second of its two clocks; the value on the first clock has no effect.
- R3: Each output nibble is sent most significant bit first. Each bit is driven unchanged for both of its clocks.
- R4: A connection entry is written with `cm_wr_addr = {output stream[7:6], output nibble slot[5:0]}` and `cm_wr_data = {source stream[8:6], source nibble[5:0]}`. Output nibble slot i of output o carries the input nibble named by entry (o, i).
- R5: Every output nibble comes from the input frame just before the current one, so the delay is exactly one frame. This holds for every slot, including output slot 0 taken from input nibble 63.
- R6: Reset clears the data memory, the connection memory and the output shifters. During the first frame after reset all outputs are 0. Entries that have not been written select input stream 0, nibble 0.
- R7: One input nibble may feed any number of output slots on any outputs at the same time.
- R8: A connection write changes only the addressed entry. The change applies from the next time that slot is loaded.
- R9: When four inputs are mapped one-to-one onto all 256 output slots, every one of those 256 input nibbles appears exactly once at its mapped position.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Interface clock, two cycles per serial bit |
| rst | input | 1 | Synchronous active-high reset |
| frame_sync | input | 1 | Frame alignment pulse: high for the first clock of nibble 0 |
| ser_in | input | N_IN (8) | Serial input streams, one bit per stream |
| ser_out | output | N_OUT (4) | Serial output streams, one bit per stream |
| cm_wr_en | input | 1 | Connection memory write strobe |
| cm_wr_addr | input | 8 | {output stream, output nibble slot} |
| cm_wr_data | input | 9 | {source stream, source nibble index} |

## Verification
The assertions check the following on every cycle:
- the position wrap from the last clock of a frame to nibble 0;
- the data bank swap, which happens exactly once, at the frame boundary;
- that each output bit is held for both of its clocks;
- that the outputs are quiet after reset.

Only the bench's scenarios can show that the right nibble lands in the right slot. These cover:
- sampling on the second clock of each bit;
- the exact one-frame delay, including input nibble 63 feeding output slot 0;
- broadcast;
- that entries not being written are left unchanged;
- the one-to-one four-input map.

// File: rtl/nsw_pkg.sv
package nsw_pkg;

    // Default geometry of the switch
    localparam int DEF_IN_STREAMS  = 8;
    localparam int DEF_OUT_STREAMS = 4;
    localparam int DEF_SLOTS       = 64;
    localparam int NIB_BITS        = 4;

    // Per-clock timing events derived from the frame position
    typedef struct packed {
        logic sample;     // second clock of a bit
        logic nib_end;    // second clock of the last bit of a nibble
        logic frame_end;  // nib_end of the last nibble in the frame
    } nsw_tick_t;

    // Width of a frame position counter: slot, bit index, clock phase
    function automatic int pos_width(int slots);
        return $clog2(slots) + $clog2(NIB_BITS) + 1;
    endfunction

endpackage

// File: rtl/nsw_frame_timer.sv
module nsw_frame_timer
    import nsw_pkg::*;
#(
    parameter  int SLOTS  = DEF_SLOTS,
    localparam int SLOT_W = $clog2(SLOTS),
    localparam int BIT_W  = $clog2(NIB_BITS),
    localparam int POS_W  = SLOT_W + BIT_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_sync,
    output logic [POS_W-1:0]  cur_pos,
    output logic [SLOT_W-1:0] slot,
    output logic              bank,
    output nsw_tick_t         tick
);

    logic [POS_W-1:0] pos_q;

    // The sync pulse forces the current clock to position zero
    always_comb cur_pos = frame_sync ? '0 : pos_q;

    assign slot = cur_pos[POS_W-1 -: SLOT_W];

    always_comb begin
        tick.sample    = cur_pos[0];
        tick.nib_end   = cur_pos[0] && (&cur_pos[BIT_W:1]);
        tick.frame_end = tick.nib_end && (&slot);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q <= '0;
            bank  <= 1'b0;
        end else begin
            pos_q <= cur_pos + POS_W'(1);
            if (tick.frame_end)
                bank <= ~bank;
        end
    end

endmodule

// File: rtl/nsw_rx_lane.sv
module nsw_rx_lane
    import nsw_pkg::*;
#(
    parameter int NB = NIB_BITS
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          sample,
    input  logic          ser_in,
    output logic [NB-1:0] nib_now
);

    // Earlier bits of the nibble, most significant first
    logic [NB-2:0] hist_q;

    assign nib_now = {hist_q, ser_in};

    always_ff @(posedge clk) begin
        if (rst)
            hist_q <= '0;
        else if (sample)
            hist_q <= nib_now[NB-2:0];
    end

endmodule

// File: rtl/nsw_data_mem.sv
module nsw_data_mem
    import nsw_pkg::*;
#(
    parameter  int N_IN   = DEF_IN_STREAMS,
    parameter  int N_OUT  = DEF_OUT_STREAMS,
    parameter  int SLOTS  = DEF_SLOTS,
    parameter  int NB     = NIB_BITS,
    localparam int SI_W   = $clog2(N_IN),
    localparam int SLOT_W = $clog2(SLOTS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              wr_bank,
    input  logic [SLOT_W-1:0] wr_slot,
    input  logic [NB-1:0]     wr_nib    [N_IN],
    input  logic              rd_bank,
    input  logic [SI_W-1:0]   rd_stream [N_OUT],
    input  logic [SLOT_W-1:0] rd_slot   [N_OUT],
    output logic [NB-1:0]     rd_nib    [N_OUT]
);

    logic [NB-1:0] store_q [2][N_IN][SLOTS];

    // All input lanes complete a nibble in the same clock
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int b = 0; b < 2; b++)
                for (int s = 0; s < N_IN; s++)
                    for (int n = 0; n < SLOTS; n++)
                        store_q[b][s][n] <= '0;
        end else if (wr_en) begin
            for (int s = 0; s < N_IN; s++)
                store_q[wr_bank][s][wr_slot] <= wr_nib[s];
        end
    end

    // Read ports; a read of the nibble being written this clock is forwarded
    for (genvar o = 0; o < N_OUT; o++) begin : g_rd
        logic fwd;
        always_comb begin
            fwd = wr_en && (rd_bank == wr_bank) && (rd_slot[o] == wr_slot);
            rd_nib[o] = fwd ? wr_nib[rd_stream[o]]
                            : store_q[rd_bank][rd_stream[o]][rd_slot[o]];
        end
    end

endmodule

// File: rtl/nsw_conn_mem.sv
module nsw_conn_mem
    import nsw_pkg::*;
#(
    parameter  int N_IN   = DEF_IN_STREAMS,
    parameter  int N_OUT  = DEF_OUT_STREAMS,
    parameter  int SLOTS  = DEF_SLOTS,
    localparam int SI_W   = $clog2(N_IN),
    localparam int SO_W   = $clog2(N_OUT),
    localparam int SLOT_W = $clog2(SLOTS),
    localparam int ENT_W  = SI_W + SLOT_W
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_en,
    input  logic [SO_W+SLOT_W-1:0] wr_addr,
    input  logic [ENT_W-1:0]       wr_data,
    input  logic [SLOT_W-1:0]      rd_slot,
    output logic [ENT_W-1:0]       rd_entry [N_OUT]
);

    logic [ENT_W-1:0] ent_q [N_OUT][SLOTS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int o = 0; o < N_OUT; o++)
                for (int n = 0; n < SLOTS; n++)
                    ent_q[o][n] <= '0;
        end else if (wr_en) begin
            ent_q[wr_addr[SO_W+SLOT_W-1 -: SO_W]][wr_addr[SLOT_W-1:0]] <= wr_data;
        end
    end

    // Every output loads the same slot in the same clock
    for (genvar o = 0; o < N_OUT; o++) begin : g_rd
        assign rd_entry[o] = ent_q[o][rd_slot];
    end

endmodule

// File: rtl/nsw_tx_lane.sv
module nsw_tx_lane
    import nsw_pkg::*;
#(
    parameter int NB = NIB_BITS
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          sample,
    input  logic          load,
    input  logic [NB-1:0] load_nib,
    output logic          ser_out
);

    logic [NB-1:0] shift_q;

    assign ser_out = shift_q[NB-1];

    always_ff @(posedge clk) begin
        if (rst)
            shift_q <= '0;
        else if (load)
            shift_q <= load_nib;
        else if (sample)
            shift_q <= {shift_q[NB-2:0], 1'b0};
    end

endmodule

// File: rtl/nib_tdm_switch.sv
module nib_tdm_switch
    import nsw_pkg::*;
#(
    parameter  int N_IN   = DEF_IN_STREAMS,
    parameter  int N_OUT  = DEF_OUT_STREAMS,
    parameter  int SLOTS  = DEF_SLOTS,
    localparam int SI_W   = $clog2(N_IN),
    localparam int SO_W   = $clog2(N_OUT),
    localparam int SLOT_W = $clog2(SLOTS),
    localparam int ENT_W  = SI_W + SLOT_W
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   frame_sync,
    input  logic [N_IN-1:0]        ser_in,
    output logic [N_OUT-1:0]       ser_out,
    input  logic                   cm_wr_en,
    input  logic [SO_W+SLOT_W-1:0] cm_wr_addr,
    input  logic [ENT_W-1:0]       cm_wr_data
);

    localparam int POS_W = pos_width(SLOTS);

    logic [POS_W-1:0]    cur_pos;
    logic [SLOT_W-1:0]   slot;
    logic [SLOT_W-1:0]   nxt_slot;
    logic                bank;
    logic                rd_bank;
    nsw_tick_t           tick;

    logic [NIB_BITS-1:0] rx_nib     [N_IN];
    logic [ENT_W-1:0]    cm_ent     [N_OUT];
    logic [SI_W-1:0]     src_stream [N_OUT];
    logic [SLOT_W-1:0]   src_slot   [N_OUT];
    logic [NIB_BITS-1:0] tx_nib     [N_OUT];

    nsw_frame_timer #(.SLOTS(SLOTS)) u_timer (
        .clk        (clk),
        .rst        (rst),
        .frame_sync (frame_sync),
        .cur_pos    (cur_pos),
        .slot       (slot),
        .bank       (bank),
        .tick       (tick)
    );

    // Outputs load the following slot at the end of each nibble. The last
    // load of a frame reads the bank that is just being completed.
    assign nxt_slot = slot + SLOT_W'(1);
    assign rd_bank  = tick.frame_end ? bank : ~bank;

    for (genvar s = 0; s < N_IN; s++) begin : g_rx
        nsw_rx_lane #(.NB(NIB_BITS)) u_rx (
            .clk     (clk),
            .rst     (rst),
            .sample  (tick.sample),
            .ser_in  (ser_in[s]),
            .nib_now (rx_nib[s])
        );
    end

    nsw_conn_mem #(.N_IN(N_IN), .N_OUT(N_OUT), .SLOTS(SLOTS)) u_cmem (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (cm_wr_en),
        .wr_addr  (cm_wr_addr),
        .wr_data  (cm_wr_data),
        .rd_slot  (nxt_slot),
        .rd_entry (cm_ent)
    );

    for (genvar o = 0; o < N_OUT; o++) begin : g_map
        assign src_stream[o] = cm_ent[o][ENT_W-1 -: SI_W];
        assign src_slot[o]   = cm_ent[o][SLOT_W-1:0];
    end

    nsw_data_mem #(.N_IN(N_IN), .N_OUT(N_OUT), .SLOTS(SLOTS), .NB(NIB_BITS)) u_dmem (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (tick.nib_end),
        .wr_bank   (bank),
        .wr_slot   (slot),
        .wr_nib    (rx_nib),
        .rd_bank   (rd_bank),
        .rd_stream (src_stream),
        .rd_slot   (src_slot),
        .rd_nib    (tx_nib)
    );

    for (genvar o = 0; o < N_OUT; o++) begin : g_tx
        nsw_tx_lane #(.NB(NIB_BITS)) u_tx (
            .clk      (clk),
            .rst      (rst),
            .sample   (tick.sample),
            .load     (tick.nib_end),
            .load_nib (tx_nib[o]),
            .ser_out  (ser_out[o])
        );
    end

endmodule

// File: rtl/nib_tdm_switch_chk.sv
module nib_tdm_switch_chk #(
    parameter int POS_W = 9,
    parameter int N_OUT = 4
) (
    input logic             clk,
    input logic             rst,
    input logic [POS_W-1:0] cur_pos,
    input logic             bank,
    input logic [N_OUT-1:0] ser_out
);

    logic rst_d;
    always_ff @(posedge clk) rst_d <= rst;

    // R1
    frame_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (cur_pos == '1) |=> (cur_pos == '0));

    // R5
    bank_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (cur_pos != '1) |=> $stable(bank));

    // R5
    bank_flip_chk: assert property (@(posedge clk) disable iff (rst)
        (cur_pos == '1) |=> (bank != $past(bank)));

    // R3
    bit_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (cur_pos[0] == 1'b0) |=> $stable(ser_out));

    // R6
    always @(negedge clk) begin
        if (rst_d)
            reset_quiet_chk: assert (ser_out == '0);
    end

endmodule

bind nib_tdm_switch nib_tdm_switch_chk #(.POS_W(POS_W), .N_OUT(N_OUT)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .cur_pos (cur_pos),
    .bank    (bank),
    .ser_out (ser_out)
);

// File: tb/nib_tdm_switch_tb.sv
module nib_tdm_switch_tb;

    localparam int N_IN  = 8;
    localparam int N_OUT = 4;
    localparam int SLOTS = 64;
    localparam int FRAME = 512;

    logic             clk = 1'b0;
    logic             rst;
    logic             frame_sync;
    logic [N_IN-1:0]  ser_in;
    logic [N_OUT-1:0] ser_out;
    logic             cm_wr_en;
    logic [7:0]       cm_wr_addr;
    logic [8:0]       cm_wr_data;

    int   vectors = 0;
    int   errs    = 0;
    bit   done    = 1'b0;
    logic [8:0] cm_model [N_OUT*SLOTS];

    always #4 clk = ~clk;

    nib_tdm_switch #(.N_IN(N_IN), .N_OUT(N_OUT), .SLOTS(SLOTS)) u_dut (
        .clk        (clk),
        .rst        (rst),
        .frame_sync (frame_sync),
        .ser_in     (ser_in),
        .ser_out    (ser_out),
        .cm_wr_en   (cm_wr_en),
        .cm_wr_addr (cm_wr_addr),
        .cm_wr_data (cm_wr_data)
    );

    // Input nibble of frame k, stream s, slot n
    function automatic logic [3:0] dat(int k, int s, int n);
        int v;
        v = k * 7 + s * 5 + n * 3 + (n / 8) * 11;
        return v[3:0];
    endfunction

    // Connection entry {stream, slot} for map mode, output o, slot i
    function automatic logic [8:0] cfg(int mode, int o, int i);
        int st;
        int sl;
        int sel [4] = '{1, 3, 4, 6};
        case (mode)
            1:       begin st = (i + o * 3) % 8; sl = (63 - i + o * 17) % 64; end
            2:       begin st = sel[o];          sl = (i * 5 + o) % 64;        end
            default: begin st = 7;               sl = 10;                      end
        endcase
        return {st[2:0], sl[5:0]};
    endfunction

    task automatic note(bit ok, string req, int act, int exp);
        vectors++;
        if (!ok) begin
            errs++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One frame: drive inputs (first clock of each bit inverted, R2),
    // optionally program a map, optionally check every output nibble.
    task automatic run_frame(int k, bit send_fs, bit chk, int mode,
                             string tag, string tag_o2);
        logic [3:0] got  [N_OUT];
        logic       held [N_OUT];
        for (int p = 0; p < FRAME; p++) begin
            int sl = p / 8;
            int b  = (p / 2) % 4;
            @(negedge clk);
            frame_sync = send_fs && (p == 0);
            for (int s = 0; s < N_IN; s++) begin
                logic [3:0] nb = dat(k, s, sl);
                ser_in[s] = (p % 2 == 1) ? nb[3-b] : ~nb[3-b];
            end
            cm_wr_en = 1'b0;
            if (mode != 0 && p < N_OUT * SLOTS) begin
                if (mode != 3 || p / SLOTS == 2) begin
                    cm_model[p] = cfg(mode, p / SLOTS, p % SLOTS);
                    cm_wr_en    = 1'b1;
                    cm_wr_addr  = 8'(p);
                    cm_wr_data  = cm_model[p];
                end
            end
            if (chk) begin
                for (int o = 0; o < N_OUT; o++) begin
                    if (p % 2 == 0) begin
                        held[o] = ser_out[o];
                    end else begin
                        note(ser_out[o] == held[o], "R3 bit held for two clocks",
                             int'(ser_out[o]), int'(held[o]));
                        got[o][3-b] = ser_out[o];
                        if (b == 3) begin
                            logic [8:0] e = cm_model[o * SLOTS + sl];
                            logic [3:0] x;
                            x = (k == 0) ? 4'd0 : dat(k - 1, int'(e[8:6]), int'(e[5:0]));
                            note(got[o] == x, (o == 2) ? tag_o2 : tag,
                                 int'(got[o]), int'(x));
                        end
                    end
                end
            end
        end
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            errs++;
            $display("FAIL R1 watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
            $finish;
        end
    end

    initial begin
        rst        = 1'b1;
        frame_sync = 1'b0;
        ser_in     = '0;
        cm_wr_en   = 1'b0;
        cm_wr_addr = '0;
        cm_wr_data = '0;
        for (int i = 0; i < N_OUT * SLOTS; i++) cm_model[i] = '0;
        repeat (5) @(negedge clk);
        rst = 1'b0;

        // R6: quiet first frame, then cleared map selects stream 0 nibble 0
        run_frame(0, 1'b1, 1'b1, 0, "R6 output zero after reset", "R6 output zero after reset");
        run_frame(1, 1'b1, 1'b1, 0, "R6 cleared map", "R6 cleared map");
        // R4 mapping over all streams, includes input nibble 63 to output slot 0
        run_frame(2, 1'b1, 1'b0, 1, "", "");
        run_frame(3, 1'b1, 1'b1, 0, "R2 R4 R5 mapped nibble one frame later",
                  "R2 R4 R5 mapped nibble one frame later");
        // R1: frame without a sync pulse keeps its alignment
        run_frame(4, 1'b0, 1'b1, 0, "R1 free-running frame", "R1 free-running frame");
        // R9: one-to-one map from four inputs
        run_frame(5, 1'b1, 1'b0, 2, "", "");
        run_frame(6, 1'b1, 1'b1, 0, "R9 four-input one-to-one map", "R9 four-input one-to-one map");
        // R7 broadcast on output 2, R8 other outputs keep the previous map
        run_frame(7, 1'b1, 1'b0, 3, "", "");
        run_frame(8, 1'b1, 1'b1, 0, "R8 unwritten entries kept", "R7 broadcast of one nibble");
        run_frame(9, 1'b1, 1'b1, 0, "R8 unwritten entries kept", "R7 broadcast of one nibble");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
        $finish;
    end

endmodule